// File: doc/BRIEF.md
# Lockable Outer Banking Register File

This block holds the outer banking configuration of a multi-game cartridge board. The board wraps an existing inner bank-switching controller. CPU writes in the $6000-$7FFF window are decoded into four register slots. Each slot is picked by the two lowest address bits, so the set repeats every four bytes across the whole window.

- The mode slot sets the top PRG and CHR address lines, the CHR banking scheme, and a strap-readback switch.
- The outer slot sets the outer PRG and CHR bank lines and their bank sizes.
- The CHR bank slot holds a fixed 8 KiB CHR bank number.
- The fourth slot accepts writes and discards them.

A lock bit in the mode slot freezes the configuration until reset. The one exception is the two low bits of the CHR bank slot, which stay writable so that a locked game can still switch between small CHR banks.

The block also owns the CPU read path for $8000-$FFFF. Normally it passes ROM data through unchanged. When strap readback is selected, the two low data bits are replaced by a 2-bit board strap. Reads anywhere below $8000 leave the bus undriven. The outputs are plain register fields, which the inner controller and the address logic consume.

Top module: `mc_outer_regs`

## Requirements
- R1: A register write occurs only on a clock edge where `cpu_we` and `cpu_sel` are both high and `cpu_addr[15:13]` equals 3'b011. The slot is chosen by `cpu_addr[1:0]`: 0 is mode, 1 is outer, 2 is CHR bank, 3 is the discarded slot. Address bits 12:2 are ignored. No other cycle changes any register output.
- R2: While `rst_n` is low, every register output is zero, the lock included. Outputs remain zero until the first accepted write.
- R3: The mode slot maps its bits to outputs as follows: bit 1 to `cfg_prg_a19`, bit 2 to `cfg_chr_a19`, bit 3 to `cfg_chr_fixed` (1 means a single CHR bank is taken from the CHR bank slot), bit 6 to `cfg_pad_read` and bit 7 to `cfg_locked`. Bits 0, 4 and 5 are not stored.
- R4: The outer slot maps its bits to outputs as follows: bits 1:0 to `cfg_prg_outer`, bit 2 to `cfg_prg_small`, bit 3 to `cfg_prg_half`, bits 5:4 to `cfg_chr_outer`, bit 6 to `cfg_chr_small` and bit 7 to `cfg_prg_nrom`.
- R5: A write to the CHR bank slot while unlocked loads all 8 bits onto `cfg_chr_bank`.
- R6: The write that sets mode bit 7 takes full effect. Every later write to the mode or outer slot is ignored until reset.
- R7: While locked, a CHR bank write updates `cfg_chr_bank[1:0]` and leaves `cfg_chr_bank[7:2]` unchanged.
- R8: A write to slot 3 changes no output.
- R9: When `cpu_we` is low and `cpu_addr[15]` is 1, `cpu_rdata_oe` is 1. In that case `cpu_rdata` equals `rom_rdata` when `cfg_pad_read` is 0. When `cfg_pad_read` is 1, it is `{rom_rdata[7:2], pad_strap}`.
- R10: When `cpu_addr[15]` is 0 or `cpu_we` is 1, `cpu_rdata_oe` is 0 and `cpu_rdata` is zero. Reads in $6000-$7FFF are therefore open bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, low means read |
| cpu_sel | input | 1 | Write qualifier |
| rom_rdata | input | 8 | PRG-ROM read data |
| pad_strap | input | 2 | Board strap value |
| cpu_rdata | output | 8 | Read data toward the CPU |
| cpu_rdata_oe | output | 1 | Read data drive enable |
| cfg_prg_a19 | output | 1 | PRG address bit 19 |
| cfg_chr_a19 | output | 1 | CHR address bit 19 |
| cfg_chr_fixed | output | 1 | Fixed 8 KiB CHR bank scheme |
| cfg_pad_read | output | 1 | Strap readback selected |
| cfg_locked | output | 1 | Configuration lock |
| cfg_prg_outer | output | 2 | PRG address bits 18:17 |
| cfg_prg_small | output | 1 | 128 KiB outer PRG bank |
| cfg_prg_half | output | 1 | PRG A14 from inner controller in whole-window mode |
| cfg_chr_outer | output | 2 | CHR address bits 18:17 |
| cfg_chr_small | output | 1 | 128 KiB outer CHR bank |
| cfg_prg_nrom | output | 1 | Whole-window PRG mode |
| cfg_chr_bank | output | 8 | Fixed CHR bank number |

## Verification
The hardest state to reach is a locked configuration whose CHR bank slot already carries non-zero upper bits. Only in that state does a locked CHR write show the split between bits that respond and bits that are held.

The stimulus works through it in order:
- It loads a pattern into the CHR slot while the block is unlocked.
- It then sets the lock with a write that also changes other mode bits.
- It then writes complementary values to all slots, each through a different mirror address.

A mid-run reset then shows the lock clearing. A reference model compared on every clock tracks each step.

// File: rtl/mc_outer_pkg.sv
// Package: shared field layouts for the outer banking register file.
// Assumes 8-bit CPU data and four register slots selected by address bits 1:0.
package mc_outer_pkg;
    localparam int DATA_W   = 8;
    localparam int SLOT_MODE  = 0;
    localparam int SLOT_OUTER = 1;
    localparam int SLOT_CHR   = 2;
    localparam int SLOT_VOID  = 3;

    typedef struct packed {
        logic       lock;
        logic       pad_read;
        logic [1:0] spare_hi;
        logic       chr_fixed;
        logic       chr_a19;
        logic       prg_a19;
        logic       spare_lo;
    } mode_t;

    typedef struct packed {
        logic       prg_nrom;
        logic       chr_small;
        logic [1:0] chr_outer;
        logic       prg_half;
        logic       prg_small;
        logic [1:0] prg_outer;
    } outer_t;

    // Bits of a slot that still accept writes while the lock is set.
    function automatic logic [DATA_W-1:0] keep_mask(input int idx);
        return (idx == SLOT_CHR) ? 8'h03 : 8'h00;
    endfunction

    // Mode slot stores only the bits that have a defined use.
    function automatic logic [DATA_W-1:0] store_mask(input int idx);
        return (idx == SLOT_MODE) ? 8'hCE : 8'hFF;
    endfunction
endpackage

// File: rtl/mc_wr_decode.sv
// Module: write decoder. Turns a qualified CPU write inside the
// $6000-$7FFF window into a one-hot slot strobe.
// Assumes the window is identified by the top three address bits being 011.
module mc_wr_decode #(
    parameter int ADDR_W  = 16,
    parameter int REG_CNT = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we,
    input  logic               sel,
    output logic [REG_CNT-1:0] hit
);
    localparam int SEL_W = $clog2(REG_CNT);

    logic in_window;
    logic unused_addr;

    // Window match on the upper address bits.
    assign in_window   = (addr[ADDR_W-1 -: 3] == 3'b011);
    assign unused_addr = ^addr[ADDR_W-4:SEL_W];

    // One-hot slot strobe for the qualified write.
    always_comb begin
        hit = '0;
        if (we && sel && in_window)
            hit[addr[SEL_W-1:0]] = 1'b1;
    end
endmodule

// File: rtl/mc_cfg_slot.sv
// Module: one configuration register slot with lock handling.
// Bits in KEEP stay writable while locked; bits outside STORE read as zero.
module mc_cfg_slot #(
    parameter int               W     = 8,
    parameter logic [W-1:0]     KEEP  = '0,
    parameter logic [W-1:0]     STORE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         locked,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] next_q;

    // Next value: all stored bits when open, only KEEP bits when locked.
    always_comb begin
        if (locked)
            next_q = (q & ~KEEP) | (d & KEEP & STORE);
        else
            next_q = d & STORE;
    end

    // Slot register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr)
            q <= next_q;
    end
endmodule

// File: rtl/mc_read_mux.sv
// Module: CPU read path for the program window. Passes ROM data, or
// overlays the board strap on the low bits when readback is selected.
// Assumes the program window is any address with the top bit set.
module mc_read_mux #(
    parameter int DATA_W  = 8,
    parameter int STRAP_W = 2
) (
    input  logic              addr_top,
    input  logic              we,
    input  logic              pad_sel,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [STRAP_W-1:0] strap,
    output logic [DATA_W-1:0] rdata,
    output logic              oe
);
    // Drive only on reads of the program window; zero otherwise.
    always_comb begin
        oe    = addr_top && !we;
        rdata = '0;
        if (oe) begin
            rdata = rom_rdata;
            if (pad_sel)
                rdata[STRAP_W-1:0] = strap;
        end
    end
endmodule

// File: rtl/mc_outer_regs.sv
// Module: outer banking register file top. Decodes window writes into
// the slots, derives the lock from the mode slot, and drives the fields.
// Assumes the inner controller and ROM sit outside this block.
module mc_outer_regs #(
    parameter int ADDR_W  = 16,
    parameter int STRAP_W = 2,
    parameter int REG_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               cpu_we,
    input  logic               cpu_sel,
    input  logic [7:0]         rom_rdata,
    input  logic [STRAP_W-1:0] pad_strap,
    output logic [7:0]         cpu_rdata,
    output logic               cpu_rdata_oe,
    output logic               cfg_prg_a19,
    output logic               cfg_chr_a19,
    output logic               cfg_chr_fixed,
    output logic               cfg_pad_read,
    output logic               cfg_locked,
    output logic [1:0]         cfg_prg_outer,
    output logic               cfg_prg_small,
    output logic               cfg_prg_half,
    output logic [1:0]         cfg_chr_outer,
    output logic               cfg_chr_small,
    output logic               cfg_prg_nrom,
    output logic [7:0]         cfg_chr_bank
);
    import mc_outer_pkg::*;

    logic [REG_CNT-1:0] wr_hit;
    logic [DATA_W-1:0]  slot_q [REG_CNT];
    logic               lock_q;
    mode_t              mode_f;
    outer_t             outer_f;

    mc_wr_decode #(.ADDR_W(ADDR_W), .REG_CNT(REG_CNT)) u_dec (
        .addr (cpu_addr),
        .we   (cpu_we),
        .sel  (cpu_sel),
        .hit  (wr_hit)
    );

    // One storing slot per defined register; the void slot discards writes.
    for (genvar i = 0; i < REG_CNT; i++) begin : g_slot
        if (i == SLOT_VOID) begin : g_void
            logic unused_void;
            assign unused_void = wr_hit[i];
            assign slot_q[i]   = '0;
        end else begin : g_store
            mc_cfg_slot #(
                .W     (DATA_W),
                .KEEP  (keep_mask(i)),
                .STORE (store_mask(i))
            ) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr     (wr_hit[i]),
                .locked (lock_q),
                .d      (cpu_wdata),
                .q      (slot_q[i])
            );
        end
    end

    // Field views of the stored slots.
    assign mode_f  = mode_t'(slot_q[SLOT_MODE]);
    assign outer_f = outer_t'(slot_q[SLOT_OUTER]);
    assign lock_q  = mode_f.lock;

    mc_read_mux #(.DATA_W(DATA_W), .STRAP_W(STRAP_W)) u_rd (
        .addr_top  (cpu_addr[ADDR_W-1]),
        .we        (cpu_we),
        .pad_sel   (mode_f.pad_read),
        .rom_rdata (rom_rdata),
        .strap     (pad_strap),
        .rdata     (cpu_rdata),
        .oe        (cpu_rdata_oe)
    );

    // Output field fan-out.
    assign cfg_prg_a19   = mode_f.prg_a19;
    assign cfg_chr_a19   = mode_f.chr_a19;
    assign cfg_chr_fixed = mode_f.chr_fixed;
    assign cfg_pad_read  = mode_f.pad_read;
    assign cfg_locked    = lock_q;
    assign cfg_prg_outer = outer_f.prg_outer;
    assign cfg_prg_small = outer_f.prg_small;
    assign cfg_prg_half  = outer_f.prg_half;
    assign cfg_chr_outer = outer_f.chr_outer;
    assign cfg_chr_small = outer_f.chr_small;
    assign cfg_prg_nrom  = outer_f.prg_nrom;
    assign cfg_chr_bank  = slot_q[SLOT_CHR];
endmodule

// File: rtl/mc_outer_regs_chk.sv
// Module: property checker for the outer banking register file, bound to the top.
module mc_outer_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_we,
    input logic        cpu_sel,
    input logic [1:0]  pad_strap,
    input logic [7:0]  cpu_rdata,
    input logic        cpu_rdata_oe,
    input logic        cfg_pad_read,
    input logic        cfg_locked,
    input logic [4:0]  mode_bits,
    input logic [7:0]  outer_bits,
    input logic [7:0]  cfg_chr_bank
);
    logic wr_ok;
    assign wr_ok = cpu_we && cpu_sel && (cpu_addr[15:13] == 3'b011);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked); // R6
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(mode_bits)); // R6
    AST_OUTER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(outer_bits)); // R6
    AST_CHR_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(cfg_chr_bank[7:2])); // R7
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable({mode_bits, outer_bits, cfg_chr_bank})); // R1
    AST_OPEN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_addr[15] || cpu_we) |-> (!cpu_rdata_oe && cpu_rdata == 8'h00)); // R10
    AST_STRAP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pad_read && cpu_addr[15] && !cpu_we) |-> (cpu_rdata[1:0] == pad_strap)); // R9
endmodule

bind mc_outer_regs mc_outer_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_we       (cpu_we),
    .cpu_sel      (cpu_sel),
    .pad_strap    (pad_strap),
    .cpu_rdata    (cpu_rdata),
    .cpu_rdata_oe (cpu_rdata_oe),
    .cfg_pad_read (cfg_pad_read),
    .cfg_locked   (cfg_locked),
    .mode_bits    ({cfg_locked, cfg_pad_read, cfg_chr_fixed, cfg_chr_a19, cfg_prg_a19}),
    .outer_bits   ({cfg_prg_nrom, cfg_chr_small, cfg_chr_outer, cfg_prg_half, cfg_prg_small, cfg_prg_outer}),
    .cfg_chr_bank (cfg_chr_bank)
);

// File: tb/mc_outer_regs_test.sv
`timescale 1ns/1ps
module mc_outer_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_we = 1'b0;
    logic        cpu_sel = 1'b0;
    logic [7:0]  rom_rdata = 8'h00;
    logic [1:0]  pad_strap = 2'b00;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;
    logic        cfg_prg_a19, cfg_chr_a19, cfg_chr_fixed, cfg_pad_read, cfg_locked;
    logic [1:0]  cfg_prg_outer, cfg_chr_outer;
    logic        cfg_prg_small, cfg_prg_half, cfg_chr_small, cfg_prg_nrom;
    logic [7:0]  cfg_chr_bank;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // Behavioural reference state.
    bit [7:0] m_mode = 0, m_outer = 0, m_chr = 0;

    always #4 clk = ~clk;

    mc_outer_regs uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmp_regs();
        check({cfg_locked, cfg_pad_read, cfg_chr_fixed, cfg_chr_a19, cfg_prg_a19} ==
              {m_mode[7], m_mode[6], m_mode[3], m_mode[2], m_mode[1]}, "R3 mode fields",
              {cfg_locked, cfg_pad_read, cfg_chr_fixed, cfg_chr_a19, cfg_prg_a19},
              {m_mode[7], m_mode[6], m_mode[3], m_mode[2], m_mode[1]});
        check({cfg_prg_nrom, cfg_chr_small, cfg_chr_outer, cfg_prg_half, cfg_prg_small, cfg_prg_outer} == m_outer,
              "R4 outer fields",
              {cfg_prg_nrom, cfg_chr_small, cfg_chr_outer, cfg_prg_half, cfg_prg_small, cfg_prg_outer}, m_outer);
        check(cfg_chr_bank == m_chr, "R5 chr bank", cfg_chr_bank, m_chr);
    endtask

    // One bus cycle: drive at negedge, check read path, step model at the edge, check registers.
    task automatic cyc(input bit [15:0] a, input bit [7:0] d, input bit we, input bit sel, input bit [7:0] rom);
        bit exp_oe;
        bit [7:0] exp_rd;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = we; cpu_sel = sel; rom_rdata = rom;
        #1;
        exp_oe = a[15] && !we;
        exp_rd = exp_oe ? (m_mode[6] ? {rom[7:2], pad_strap} : rom) : 8'h00;
        check(cpu_rdata_oe == exp_oe, exp_oe ? "R9 read enable" : "R10 open bus enable", cpu_rdata_oe, exp_oe);
        check(cpu_rdata == exp_rd, exp_oe ? "R9 read data" : "R10 open bus data", cpu_rdata, exp_rd);
        @(posedge clk);
        if (rst_n && we && sel && a[15:13] == 3'b011) begin
            case (a[1:0])
                2'd0: if (!m_mode[7]) m_mode = d & 8'hCE;
                2'd1: if (!m_mode[7]) m_outer = d;
                2'd2: m_chr = m_mode[7] ? {m_chr[7:2], d[1:0]} : d;
                default: ;
            endcase
        end
        #1;
        cmp_regs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        m_mode = 0; m_outer = 0; m_chr = 0;
        check({cfg_locked, cfg_chr_bank, cfg_prg_outer, cfg_prg_nrom} == 0, "R2 reset clears", cfg_chr_bank, 0);
        cmp_regs();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        pad_strap = 2'b10;
        repeat (2) @(posedge clk);
        do_reset();
        // R1/R4: outer slot through a mirror address.
        cyc(16'h7FFD, 8'hA5, 1, 1, 8'h00);
        // R3: mode with readback, fixed CHR, both A19 bits.
        cyc(16'h6000, 8'h4F, 1, 1, 8'h00);
        // R9: reads under strap readback.
        cyc(16'h8000, 8'h00, 0, 0, 8'hFC);
        cyc(16'hFFFF, 8'h00, 0, 1, 8'h57);
        // R10: reads of the register window are open bus.
        cyc(16'h6001, 8'h00, 0, 1, 8'hFF);
        // R5: CHR bank.
        cyc(16'h6A02, 8'hF1, 1, 1, 8'h00);
        // R1: unqualified or out-of-window writes.
        cyc(16'h6000, 8'h00, 1, 0, 8'h00);
        cyc(16'h4001, 8'h00, 1, 1, 8'h00);
        cyc(16'h8002, 8'h00, 1, 1, 8'h00);
        check(cfg_chr_bank == 8'hF1, "R1 stray writes ignored", cfg_chr_bank, 8'hF1);
        // R8: discarded slot.
        cyc(16'h7003, 8'hFF, 1, 1, 8'h00);
        check(cfg_prg_outer == 2'b01 && cfg_chr_bank == 8'hF1, "R8 slot 3 no effect", cfg_chr_bank, 8'hF1);
        // R6: locking write takes full effect.
        cyc(16'h6004, 8'h8A, 1, 1, 8'h00);
        check(cfg_locked && !cfg_pad_read && cfg_chr_fixed, "R6 locking write applied", cfg_locked, 1);
        cyc(16'h6100, 8'h00, 1, 1, 8'h00);
        cyc(16'h7F01, 8'h5A, 1, 1, 8'h00);
        check(cfg_locked && cfg_prg_outer == 2'b01, "R6 locked writes ignored", cfg_prg_outer, 1);
        // R7: locked CHR write.
        cyc(16'h6006, 8'h0E, 1, 1, 8'h00);
        check(cfg_chr_bank == 8'hF2, "R7 locked chr split", cfg_chr_bank, 8'hF2);
        cyc(16'h9000, 8'h00, 0, 0, 8'h33);
        // R2: reset clears the lock; block writable again.
        do_reset();
        cyc(16'h6001, 8'h3C, 1, 1, 8'h00);
        check(cfg_chr_outer == 2'b11 && cfg_prg_half, "R2 writable after reset", cfg_chr_outer, 3);
        // R9: plain ROM read with readback off.
        pad_strap = 2'b01;
        cyc(16'hC123, 8'h00, 0, 0, 8'hAB);
        cyc(16'h6000, 8'h40, 1, 1, 8'h00);
        cyc(16'hC123, 8'h00, 0, 0, 8'hAB);
        for (int k = 0; k < 16; k++)
            cyc(16'h6000 + 16'(k * 257), 8'(k * 37), 1'(k % 3 != 0), 1'(k % 4 != 1), 8'(k * 11));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #100000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule